// File: doc/BRIEF.md
# Windowed Error-Rate Clock Period Controller

This block decides, from the stream of timing-error pulses raised by a pipeline's shadow-register comparators, whether the clock period should be shortened, lengthened or left as it is. It keeps a rolling history of `NUM_SUB` equal sub-windows, each `SUB_LEN` cycles long. A saturating counter belongs to each sub-window. At the end of every sub-window the sum of all counters is graded against four programmable thresholds. The grade selects a coarse or fine step down, a coarse or fine step up, or a hold. The oldest counter is then cleared and becomes the one that counts.

A separate error cap acts at once. As soon as the summed history reaches the cap, the period is raised by the coarse step and the history rotates early, without waiting for the end of the sub-window. The period starts at its worst-case value `PER_MAX`. The phase offset of the shadow clock always equals `PER_MAX - period`. The phase may never exceed `PHASE_LIM`, so the period never falls below `PER_MAX - PHASE_LIM`. Both values go to an external clock generator.

After every change the block requests a pipeline stall. It walks a three-state sequence, `ST_RUN` to `ST_DROP` to `ST_RELOCK` and back to `ST_RUN`. This waits for the clock manager to drop lock and then for both lock indications to return. The transitions are:
- RUN→DROP: a period change.
- DROP→RELOCK: either lock is low.
- RELOCK→RUN: both locks are high.

Top module: `errwin_freq_ctrl`

## Requirements
- R1: After reset:
  - `period` = `PER_MAX` and `phase` = 0.
  - `stall` = 0 and `retune` = 0.
  - All sub-counters and the sub-window timer are zero.
- R2: Each cycle with `err_pulse` high adds one to the current sub-counter. Every `SUB_LEN` cycles (a sample point) the sum of all sub-counters, as held before that edge, is graded. The counter after the current one in rotation order is then cleared and becomes current. Rotation also happens while stalled.
- R3: A sub-counter saturates at 2^`CNT_W`-1 and never wraps.
- R4: At a sample point in `ST_RUN`, the grade is taken in this priority:
  - sum > `thr_up_far`: step up by `STEP_COARSE`.
  - else sum > `thr_up`: step up by `STEP_FINE`.
  - else sum < `thr_dn_far`: step down by `STEP_COARSE`.
  - else sum < `thr_dn`: step down by `STEP_FINE`.
  - otherwise: hold.
- R5: `period` is clamped to the range `PER_MAX-PHASE_LIM` to `PER_MAX`, and `phase` always equals `PER_MAX - period`.
- R6: In `ST_RUN`, whenever the sum is at least `err_cap` (checked every cycle):
  - The period steps up by `STEP_COARSE`.
  - The history rotates at once and the sub-window timer restarts.
  - This overrides a sample-point grade in the same cycle.
- R7: `retune` is high for exactly one cycle, the cycle in which the new `period`/`phase` first appear. There is no pulse when clamping leaves the period unchanged.
- R8: `stall` rises together with `retune`. It stays high until either lock has been sampled low and then both locks have been sampled high. It falls in the cycle after that sample.
- R9: While `stall` is high, neither sample points nor the error cap change the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_pulse | input | 1 | One timing error detected this cycle |
| lock_main | input | 1 | Main clock locked |
| lock_shift | input | 1 | Phase-shifted clock locked |
| thr_dn_far | input | SUM_W | Below this sum: coarse step down |
| thr_dn | input | SUM_W | Below this sum: fine step down |
| thr_up | input | SUM_W | Above this sum: fine step up |
| thr_up_far | input | SUM_W | Above this sum: coarse step up |
| err_cap | input | SUM_W | Sum at or above which an immediate step up occurs |
| period | output | PER_W | Requested clock period |
| phase | output | PER_W | Requested shadow-clock phase offset |
| retune | output | 1 | One-cycle pulse: new period/phase valid |
| stall | output | 1 | Pipeline stall while clocks relock |

## Verification
A wrong sub-counter, pointer or timer state never shows directly at the ports. It shows as a period step that is wrong in size, direction or timing at the next sample point, at most `SUB_LEN` cycles later. It can also show as an early cap step within a cycle of the corrupted sum. The bench follows the history in its own arithmetic model and compares `period`, `phase`, `retune` and `stall` in every cycle. A counter that wraps is exposed because the error cap is only reachable through saturated counters. A stall that is released too early or too late shows at once against the lock handshake driven by the bench.

// File: rtl/errwin_pkg.sv
package errwin_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DROP   = 2'd1,
        ST_RELOCK = 2'd2
    } ctl_state_t;

    typedef enum logic [2:0] {
        ACT_HOLD      = 3'd0,
        ACT_UP_FINE   = 3'd1,
        ACT_UP_COARSE = 3'd2,
        ACT_DN_FINE   = 3'd3,
        ACT_DN_COARSE = 3'd4
    } step_act_t;

endpackage

// File: rtl/errwin_subcnt.sv
module errwin_subcnt #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && inc && !clr) |=> (cnt == CNT_MAX)); // R3
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R2

endmodule

// File: rtl/errwin_band.sv
module errwin_band
    import errwin_pkg::*;
#(
    parameter int SUM_W = 18
) (
    input  logic [SUM_W-1:0] sum,
    input  logic [SUM_W-1:0] thr_dn_far,
    input  logic [SUM_W-1:0] thr_dn,
    input  logic [SUM_W-1:0] thr_up,
    input  logic [SUM_W-1:0] thr_up_far,
    output step_act_t        act
);
    always_comb begin
        if (sum > thr_up_far) begin
            act = ACT_UP_COARSE;
        end else if (sum > thr_up) begin
            act = ACT_UP_FINE;
        end else if (sum < thr_dn_far) begin
            act = ACT_DN_COARSE;
        end else if (sum < thr_dn) begin
            act = ACT_DN_FINE;
        end else begin
            act = ACT_HOLD;
        end
    end

endmodule

// File: rtl/errwin_freq_ctrl.sv
module errwin_freq_ctrl
    import errwin_pkg::*;
#(
    parameter int SUB_LEN     = 20000,
    parameter int NUM_SUB     = 5,
    parameter int CNT_W       = 15,
    parameter int PER_W       = 16,
    parameter int PER_MAX     = 1000,
    parameter int PHASE_LIM   = 300,
    parameter int STEP_FINE   = 4,
    parameter int STEP_COARSE = 20,
    localparam int SUM_W      = CNT_W + $clog2(NUM_SUB + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_pulse,
    input  logic             lock_main,
    input  logic             lock_shift,
    input  logic [SUM_W-1:0] thr_dn_far,
    input  logic [SUM_W-1:0] thr_dn,
    input  logic [SUM_W-1:0] thr_up,
    input  logic [SUM_W-1:0] thr_up_far,
    input  logic [SUM_W-1:0] err_cap,
    output logic [PER_W-1:0] period,
    output logic [PER_W-1:0] phase,
    output logic             retune,
    output logic             stall
);
    localparam int TICK_W = (SUB_LEN > 1) ? $clog2(SUB_LEN) : 1;
    localparam int PTR_W  = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1;
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(SUB_LEN - 1);
    localparam logic [PTR_W-1:0]  PTR_LAST  = PTR_W'(NUM_SUB - 1);
    localparam logic [PER_W:0]    MAX_X     = (PER_W+1)'(PER_MAX);
    localparam logic [PER_W:0]    FLOOR_X   = (PER_W+1)'(PER_MAX - PHASE_LIM);
    localparam logic [PER_W:0]    FINE_X    = (PER_W+1)'(STEP_FINE);
    localparam logic [PER_W:0]    COARSE_X  = (PER_W+1)'(STEP_COARSE);

    ctl_state_t state, state_nxt;
    logic [TICK_W-1:0] tick;
    logic [PTR_W-1:0]  cur, nxt;
    logic [NUM_SUB-1:0] inc_vec, clr_vec;
    logic [CNT_W-1:0]  cnt_arr [NUM_SUB];
    logic [SUM_W-1:0]  sum;
    logic              at_sample, cap_fire, rotate;
    step_act_t         band_act, act;
    logic [PER_W:0]    step_x, up_x, dn_x;
    logic [PER_W-1:0]  per_nxt;
    logic              per_change;

    // ---------------- sub-window history ----------------
    assign at_sample = (tick == TICK_LAST);
    assign cap_fire  = (state == ST_RUN) && (sum >= err_cap);
    assign rotate    = at_sample || cap_fire;
    assign nxt       = (cur == PTR_LAST) ? '0 : cur + 1'b1;

    for (genvar gi = 0; gi < NUM_SUB; gi++) begin : g_sub
        assign inc_vec[gi] = err_pulse && (cur == PTR_W'(gi));
        assign clr_vec[gi] = rotate && (nxt == PTR_W'(gi));
        errwin_subcnt #(.CNT_W(CNT_W)) i_subcnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_vec[gi]),
            .clr   (clr_vec[gi]),
            .cnt   (cnt_arr[gi])
        );
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < NUM_SUB; k++) begin
            sum = sum + SUM_W'(cnt_arr[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick <= '0;
            cur  <= '0;
        end else if (rotate) begin
            tick <= '0;
            cur  <= nxt;
        end else begin
            tick <= tick + 1'b1;
        end
    end

    // ---------------- grading and period arithmetic ----------------
    errwin_band #(.SUM_W(SUM_W)) i_band (
        .sum        (sum),
        .thr_dn_far (thr_dn_far),
        .thr_dn     (thr_dn),
        .thr_up     (thr_up),
        .thr_up_far (thr_up_far),
        .act        (band_act)
    );

    always_comb begin
        if (cap_fire) begin
            act = ACT_UP_COARSE;
        end else if ((state == ST_RUN) && at_sample) begin
            act = band_act;
        end else begin
            act = ACT_HOLD;
        end
    end

    always_comb begin
        step_x = ((act == ACT_UP_COARSE) || (act == ACT_DN_COARSE)) ? COARSE_X : FINE_X;
        up_x   = {1'b0, period} + step_x;
        dn_x   = {1'b0, period} - step_x;
        unique case (act)
            ACT_UP_FINE, ACT_UP_COARSE:
                per_nxt = (up_x > MAX_X) ? MAX_X[PER_W-1:0] : up_x[PER_W-1:0];
            ACT_DN_FINE, ACT_DN_COARSE:
                per_nxt = ({1'b0, period} < (FLOOR_X + step_x)) ? FLOOR_X[PER_W-1:0]
                                                                : dn_x[PER_W-1:0];
            default:
                per_nxt = period;
        endcase
        per_change = (per_nxt != period);
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN:    if (per_change)               state_nxt = ST_DROP;
            ST_DROP:   if (!(lock_main && lock_shift)) state_nxt = ST_RELOCK;
            ST_RELOCK: if (lock_main && lock_shift)    state_nxt = ST_RUN;
            default:                                 state_nxt = ST_RUN;
        endcase
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= PER_W'(PER_MAX);
            phase  <= '0;
            retune <= 1'b0;
        end else begin
            period <= per_nxt;
            phase  <= PER_W'(PER_MAX) - per_nxt;
            retune <= per_change;
        end
    end

    assign stall = (state != ST_RUN);

    AST_PERIOD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, period} >= FLOOR_X) && ({1'b0, period} <= MAX_X)); // R5
    AST_PHASE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (PER_W'(period + phase) == PER_W'(PER_MAX))); // R5
    AST_RETUNE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        retune |=> !retune); // R7
    AST_RETUNE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        retune |-> stall); // R8
    AST_FROZEN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(period)); // R9
    AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_vec)); // R2

endmodule

// File: tb/test_errwin_freq_ctrl.sv
module test_errwin_freq_ctrl;
    localparam int SUB_LEN = 20;
    localparam int NSUB    = 5;
    localparam int CNT_W   = 4;
    localparam int PER_W   = 8;
    localparam int PMAX    = 100;
    localparam int PLIM    = 12;
    localparam int FINE    = 2;
    localparam int COARSE  = 5;
    localparam int SUM_W   = CNT_W + $clog2(NSUB + 1);
    localparam int FLOOR   = PMAX - PLIM;
    localparam int CMAX    = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic err_pulse = 1'b0;
    logic lock_main = 1'b1, lock_shift = 1'b1;
    logic [SUM_W-1:0] thr_dn_far = 2, thr_dn = 6, thr_up = 14, thr_up_far = 24, err_cap = 127;
    logic [PER_W-1:0] period, phase;
    logic retune, stall;

    int n_chk = 0, n_err = 0;
    string tag = "R1";
    int lock_delay = 3, lock_cnt = 0;
    int n_retune = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    errwin_freq_ctrl #(
        .SUB_LEN(SUB_LEN), .NUM_SUB(NSUB), .CNT_W(CNT_W), .PER_W(PER_W),
        .PER_MAX(PMAX), .PHASE_LIM(PLIM), .STEP_FINE(FINE), .STEP_COARSE(COARSE)
    ) i_errwin_freq_ctrl (
        .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse),
        .lock_main(lock_main), .lock_shift(lock_shift),
        .thr_dn_far(thr_dn_far), .thr_dn(thr_dn), .thr_up(thr_up),
        .thr_up_far(thr_up_far), .err_cap(err_cap),
        .period(period), .phase(phase), .retune(retune), .stall(stall)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- arithmetic reference of the requirements ----------------
    int m_cnt [NSUB];
    int m_tick, m_cur, m_st, m_per, m_req;
    int s_sum, s_np, s_stp, s_dir, s_nx;
    bit s_at, s_cap, s_rot;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NSUB; k++) m_cnt[k] = 0;
            m_tick = 0; m_cur = 0; m_st = 0; m_per = PMAX; m_req = 0;
        end else begin
            s_sum = 0;
            for (int k = 0; k < NSUB; k++) s_sum += m_cnt[k];
            s_at  = (m_tick == SUB_LEN - 1);
            s_cap = (m_st == 0) && (s_sum >= int'(err_cap));
            s_dir = 0; s_stp = 0;
            if (s_cap) begin s_dir = 1; s_stp = COARSE; end
            else if (m_st == 0 && s_at) begin
                if (s_sum > int'(thr_up_far))      begin s_dir = 1;  s_stp = COARSE; end
                else if (s_sum > int'(thr_up))     begin s_dir = 1;  s_stp = FINE;   end
                else if (s_sum < int'(thr_dn_far)) begin s_dir = -1; s_stp = COARSE; end
                else if (s_sum < int'(thr_dn))     begin s_dir = -1; s_stp = FINE;   end
            end
            s_np = m_per;
            if (s_dir > 0) s_np = (m_per + s_stp > PMAX) ? PMAX : m_per + s_stp;
            if (s_dir < 0) s_np = (m_per - s_stp < FLOOR) ? FLOOR : m_per - s_stp;
            s_rot = s_at || s_cap;
            s_nx  = (m_cur + 1) % NSUB;
            if (err_pulse && m_cnt[m_cur] < CMAX) m_cnt[m_cur] = m_cnt[m_cur] + 1;
            if (s_rot) begin m_cnt[s_nx] = 0; m_cur = s_nx; m_tick = 0; end
            else m_tick = m_tick + 1;
            case (m_st)
                0: if (s_np != m_per) m_st = 1;
                1: if (!(lock_main && lock_shift)) m_st = 2;
                default: if (lock_main && lock_shift) m_st = 0;
            endcase
            m_req = (s_np != m_per) ? 1 : 0;
            m_per = s_np;
        end
    end

    // per-cycle comparison and lock responder, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(tag, int'(period), m_per, "period");
            check(tag, int'(phase), PMAX - m_per, "phase");
            check("R7", int'(retune), m_req, "retune");
            check("R8", int'(stall), (m_st != 0) ? 1 : 0, "stall");
            if (retune) n_retune++;
        end
        if (rst_n && retune) begin
            lock_main <= 1'b0; lock_shift <= 1'b0; lock_cnt <= lock_delay;
        end else if (lock_cnt > 1) begin
            lock_cnt <= lock_cnt - 1;
        end else if (lock_cnt == 1) begin
            lock_cnt <= 0; lock_main <= 1'b1; lock_shift <= 1'b1;
        end
    end

    task automatic run(input int n, input int every);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            err_pulse = (every > 0) && (c % every == 0);
        end
    endtask

    task automatic run_until_retune(input int every, input int limit, output int used);
        used = limit;
        for (int c = 0; c < limit; c++) begin
            @(negedge clk);
            if (retune) begin used = c; err_pulse = 1'b0; break; end
            err_pulse = (every > 0) && (c % every == 0);
        end
        err_pulse = 1'b0;
    endtask

    task automatic wait_run();
        for (int c = 0; c < 500; c++) begin
            @(negedge clk);
            if (!stall) break;
        end
    endtask

    int p0, used, r0;
    bit moved;

    initial begin
        // R1: reset values
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(period), PMAX, "reset period");
        check("R1", int'(phase), 0, "reset phase");
        check("R1", int'(stall), 0, "reset stall");
        check("R1", int'(retune), 0, "reset retune");

        // R4/R5: silence walks the period to the floor by coarse steps
        tag = "R4";
        r0 = n_retune;
        run(600, 0);
        wait_run();
        check("R5", int'(period), FLOOR, "floor period");
        check("R5", int'(phase), PLIM, "floor phase");
        check("R7", n_retune - r0, 3, "retunes 100->95->90->88");

        // R3/R6: cap only reachable with saturated counters
        tag = "R3";
        thr_dn_far = 0; thr_dn = 0; thr_up = 127; thr_up_far = 127; err_cap = 70;
        run_until_retune(1, 200, used);
        check("R3", (used < 200) ? 1 : 0, 1, "cap reached via saturation");
        check("R6", (used >= 69) ? 1 : 0, 1, "cap not before 70 errors");
        @(negedge clk);
        check("R6", int'(period), FLOOR + COARSE, "cap step");
        wait_run();
        err_cap = 127;
        run(120, 0);
        check("R2", int'(period), FLOOR + COARSE, "hold with never-firing bands");

        // R4: bands under several error densities
        tag = "R4";
        thr_dn_far = 2; thr_dn = 6; thr_up = 14; thr_up_far = 24;
        run(200, 12);
        p0 = int'(period);
        run(100, 12);
        check("R4", int'(period), p0, "hold band steady");
        p0 = int'(period);
        run(300, 5);
        check("R4", (int'(period) > p0) ? 1 : 0, 1, "fine up band");

        // R9: decisions ignored while stalled, then R6 cap
        tag = "R9";
        thr_dn_far = 127; thr_dn = 127; thr_up = 127; thr_up_far = 127;
        lock_delay = 50;
        run_until_retune(0, 200, used);
        p0 = int'(period);
        err_cap = 5;
        moved = 1'b0;
        for (int c = 0; c < 45; c++) begin
            @(negedge clk);
            err_pulse = 1'b1;
            if (int'(period) != p0) moved = 1'b1;
        end
        check("R9", int'(moved), 0, "period frozen during stall");
        check("R8", int'(stall), 1, "stall held while relocking");
        lock_delay = 3;
        err_pulse = 1'b0;
        wait_run();
        @(negedge clk); @(negedge clk);
        tag = "R6";
        check("R6", int'(period), (p0 + COARSE > PMAX) ? PMAX : p0 + COARSE, "cap after relock");

        // R5/R7: heavy errors drive to the ceiling, then no more pulses
        tag = "R5";
        thr_up = 14; thr_up_far = 24; thr_dn = 6; thr_dn_far = 2;
        run(600, 2);
        wait_run();
        check("R5", int'(period), PMAX, "ceiling period");
        check("R5", int'(phase), 0, "ceiling phase");
        r0 = n_retune;
        run(200, 2);
        check("R7", n_retune - r0, 0, "no pulse when clamped");

        // R1: reset mid-run
        run(30, 0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R1", int'(period), PMAX, "re-reset period");
        check("R1", int'(stall), 0, "re-reset stall");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule